// File: doc/BRIEF.md
# Six-Button Gamepad Multiplexer

This block models the controller side of a game pad that reports twelve buttons over six data lines. The host drives a select level and a write strobe. The block returns a 7-bit value. Bit 6 always shows the select level. Bits 5:0 carry button states, active low, in an arrangement chosen by the select level and by an internal phase.

In six-button mode, the phase counts select rising edges. The third and fourth reads of a burst reveal the extra buttons: X, Y, Z and Mode. A host that stops writing for a programmable number of cycles finds the pad back at phase 0. In three-button mode, the phase is tracked but never affects the output.

Button input `btn_i` is active high. The bit positions are: 0 Up, 1 Down, 2 Left, 3 Right, 4 B, 5 C, 6 A, 7 Start, 8 Z, 9 Y, 10 X, 11 Mode.

Top module: `pad_mux`

## Requirements
- R1: While `rst_ni` is low, the phase and idle count are 0 and the stored select level is 0.
- R2: With select high and the phase not 3 (or in three-button mode), `data_o[5:0]` = {~C, ~B, ~Right, ~Left, ~Down, ~Up}.
- R3: With select low and the phase 0, 1 or 3-less-normal (phase 0 or 1, or three-button mode, or phase 2 in three-button mode), `data_o[5:0]` = {~Start, ~A, 0, 0, ~Down, ~Up}.
- R4: `data_o[6]` equals `sel_i` in every cycle.
- R5: The phase advances by one on a clock edge where `sel_i` is 1 and the level stored on the previous edge was 0. It wraps from 3 to 0. No other change of `sel_i` moves it.
- R6: In six-button mode, at phase 2 with select low, `data_o[5:0]` = {~Start, ~A, 0, 0, 0, 0}.
- R7: In six-button mode, at phase 3 with select high, `data_o[5:0]` = {~C, ~B, ~Mode, ~X, ~Y, ~Z}.
- R8: In six-button mode, at phase 3 with select low, `data_o[5:0]` = {~Start, ~A, 1, 1, 1, 1}.
- R9: With `six_mode_i` low, the output follows R2/R3 whatever the phase.
- R10: `wr_i` clears the idle count on the next edge. Otherwise the idle count increments, saturating. On an edge without `wr_i` where the idle count is at least `idle_lim_i`, the phase returns to 0.
- R11: If a select rising edge meets the idle timeout on the same edge, the phase becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| six_mode_i | input | 1 | 1: six-button behaviour, 0: three-button |
| sel_i | input | 1 | Host select level |
| wr_i | input | 1 | Host port write strobe |
| idle_lim_i | input | IDLE_W | Idle cycles before the phase returns to 0 |
| btn_i | input | 12 | Button states, active high |
| data_o | output | 7 | {select, six active-low data lines} |

## Verification
A select rising edge can arrive on the same edge on which the idle timeout fires. The bench provokes this in two steps. It first sets a small idle limit and lets the count saturate with no writes. It then raises select with the write strobe held low. The behavioural model counts the rise from a cleared phase, so it expects phase 1, and the following low and high reads must show the phase 1 encodings. A write on the rising edge instead suppresses the timeout, and that case is run as well.

// File: rtl/pad_pkg.sv
package pad_pkg;
  localparam int BTN_N   = 12;
  localparam int B_UP    = 0;
  localparam int B_DOWN  = 1;
  localparam int B_LEFT  = 2;
  localparam int B_RIGHT = 3;
  localparam int B_B     = 4;
  localparam int B_C     = 5;
  localparam int B_A     = 6;
  localparam int B_START = 7;
  localparam int B_Z     = 8;
  localparam int B_Y     = 9;
  localparam int B_X     = 10;
  localparam int B_MODE  = 11;
  localparam int DATA_W  = 7;
endpackage

// File: rtl/pad_phase_ctr.sv
module pad_phase_ctr #(
  parameter int PHASES = 4,
  parameter int IDLE_W = 16,
  localparam int PW = $clog2(PHASES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [IDLE_W-1:0] idle_lim_i,
  output logic [PW-1:0]     phase_o,
  output logic [IDLE_W-1:0] idle_o
);
  localparam logic [PW-1:0]     PH_LAST  = PW'(PHASES - 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

  logic              sel_q;
  logic [PW-1:0]     phase_q, phase_base, phase_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic              rise, timeout;

  assign rise       = sel_i & ~sel_q;
  assign timeout    = ~wr_i & (idle_q >= idle_lim_i);
  // timeout clears first, so a coincident rise counts from zero
  assign phase_base = timeout ? '0 : phase_q;

  always_comb begin
    phase_d = phase_base;
    if (rise) phase_d = (phase_base == PH_LAST) ? '0 : phase_base + 1'b1;
  end

  always_comb begin
    if (wr_i)                  idle_d = '0;
    else if (idle_q != IDLE_MAX) idle_d = idle_q + 1'b1;
    else                       idle_d = idle_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      phase_q <= '0;
      idle_q  <= '0;
    end else begin
      sel_q   <= sel_i;
      phase_q <= phase_d;
      idle_q  <= idle_d;
    end
  end

  assign phase_o = phase_q;
  assign idle_o  = idle_q;
endmodule

// File: rtl/pad_encode.sv
module pad_encode
  import pad_pkg::*;
#(
  parameter int PW = 2
) (
  input  logic             six_mode_i,
  input  logic             sel_i,
  input  logic [PW-1:0]    phase_i,
  input  logic [BTN_N-1:0] btn_i,
  output logic [DATA_W-1:0] data_o
);
  logic [BTN_N-1:0] n;   // active-low view
  logic [5:0]       lines;
  logic             ph2, ph3;

  assign n   = ~btn_i;
  assign ph2 = six_mode_i & (phase_i == PW'(2));
  assign ph3 = six_mode_i & (phase_i == PW'(3));

  always_comb begin
    if (sel_i) begin
      if (ph3) lines = {n[B_C], n[B_B], n[B_MODE], n[B_X], n[B_Y], n[B_Z]};
      else     lines = {n[B_C], n[B_B], n[B_RIGHT], n[B_LEFT], n[B_DOWN], n[B_UP]};
    end else begin
      if (ph3)      lines = {n[B_START], n[B_A], 4'b1111};
      else if (ph2) lines = {n[B_START], n[B_A], 4'b0000};
      else          lines = {n[B_START], n[B_A], 2'b00, n[B_DOWN], n[B_UP]};
    end
  end

  assign data_o = {sel_i, lines};
endmodule

// File: rtl/pad_mux.sv
module pad_mux
  import pad_pkg::*;
#(
  parameter int PHASES = 4,
  parameter int IDLE_W = 16,
  localparam int PW = $clog2(PHASES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              six_mode_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [IDLE_W-1:0] idle_lim_i,
  input  logic [BTN_N-1:0]  btn_i,
  output logic [DATA_W-1:0] data_o
);
  logic [PW-1:0]     phase_q;
  logic [IDLE_W-1:0] idle_q;

  pad_phase_ctr #(.PHASES(PHASES), .IDLE_W(IDLE_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .wr_i       (wr_i),
    .idle_lim_i (idle_lim_i),
    .phase_o    (phase_q),
    .idle_o     (idle_q)
  );

  pad_encode #(.PW(PW)) u_enc (
    .six_mode_i (six_mode_i),
    .sel_i      (sel_i),
    .phase_i    (phase_q),
    .btn_i      (btn_i),
    .data_o     (data_o)
  );
endmodule

// File: rtl/pad_mux_chk.sv
module pad_mux_chk
  import pad_pkg::*;
#(
  parameter int PW     = 2,
  parameter int IDLE_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              six_mode_i,
  input logic              sel_i,
  input logic              wr_i,
  input logic [IDLE_W-1:0] idle_lim_i,
  input logic [BTN_N-1:0]  btn_i,
  input logic [DATA_W-1:0] data_o,
  input logic [PW-1:0]     phase_i,
  input logic [IDLE_W-1:0] idle_i
);
  logic sel_prev;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sel_prev <= 1'b0;
    else         sel_prev <= sel_i;

  assert_sel_mirror_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_o[6] == sel_i);

  assert_phase_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(sel_i && !sel_prev) && (wr_i || idle_i < idle_lim_i)) |=> $stable(phase_i));

  assert_wr_clears_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> idle_i == '0);

  assert_rise_on_timeout_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !sel_prev && !wr_i && idle_i >= idle_lim_i) |=> phase_i == PW'(1));

  assert_three_btn_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!six_mode_i && sel_i) |-> data_o[5:0] == ~btn_i[5:0]);

  assert_ph2_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (six_mode_i && phase_i == PW'(2) && !sel_i) |-> data_o[3:0] == 4'h0);

  assert_ph3_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (six_mode_i && phase_i == PW'(3) && !sel_i) |-> data_o[3:0] == 4'hf);
endmodule

bind pad_mux pad_mux_chk #(.PW(PW), .IDLE_W(IDLE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .six_mode_i (six_mode_i),
  .sel_i      (sel_i),
  .wr_i       (wr_i),
  .idle_lim_i (idle_lim_i),
  .btn_i      (btn_i),
  .data_o     (data_o),
  .phase_i    (phase_q),
  .idle_i     (idle_q)
);

// File: tb/sim_pad_mux.sv
module sim_pad_mux;
  localparam int IDLE_W = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              six_mode_i = 1'b0;
  logic              sel_i = 1'b0;
  logic              wr_i = 1'b0;
  logic [IDLE_W-1:0] idle_lim_i = 16'd1000;
  logic [11:0]       btn_i = '0;
  logic [6:0]        data_o;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference state
  int m_phase = 0;
  int m_idle = 0;
  bit m_prev = 0;

  always #10 clk = ~clk;

  pad_mux u0 (
    .clk_i(clk), .rst_ni(rst_ni), .six_mode_i(six_mode_i), .sel_i(sel_i),
    .wr_i(wr_i), .idle_lim_i(idle_lim_i), .btn_i(btn_i), .data_o(data_o)
  );

  function automatic bit nb(int idx);
    return !btn_i[idx];
  endfunction

  function automatic logic [6:0] expect_out();
    logic [5:0] l;
    int ph;
    ph = six_mode_i ? m_phase : 0;
    if (sel_i && ph == 3)
      l = {nb(5), nb(4), nb(11), nb(10), nb(9), nb(8)};
    else if (sel_i)
      l = {nb(5), nb(4), nb(3), nb(2), nb(1), nb(0)};
    else if (ph == 3)
      l = {nb(7), nb(6), 4'b1111};
    else if (ph == 2)
      l = {nb(7), nb(6), 4'b0000};
    else
      l = {nb(7), nb(6), 2'b00, nb(1), nb(0)};
    return {sel_i, l};
  endfunction

  // model update
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_phase = 0; m_idle = 0; m_prev = 0;
    end else begin
      if (!wr_i && m_idle >= int'(idle_lim_i)) m_phase = 0;
      if (sel_i && !m_prev) m_phase = (m_phase + 1) % 4;
      if (wr_i) m_idle = 0;
      else if (m_idle < 65535) m_idle++;
      m_prev = sel_i;
    end
  end

  always @(negedge clk) begin
    logic [6:0] e;
    e = expect_out();
    vectors++;
    if (data_o !== e) begin
      miscompares++;
      $display("FAIL %s: data_o=%b expected=%b at %0t", cur_req, data_o, e, $time);
    end
  end

  task automatic drive(bit s, bit w, logic [11:0] b);
    @(posedge clk); #5;
    sel_i = s; wr_i = w; btn_i = b;
  endtask

  // host-style write of the select line
  task automatic put(bit s, logic [11:0] b);
    drive(s, 1'b1, b);
    drive(s, 1'b0, b);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    btn_i = 12'h0a5;
    repeat (3) @(posedge clk);
    #5 rst_ni = 1'b1;

    // R9 R2 R3 R4: three-button, phase ignored
    cur_req = "R9";
    for (int k = 0; k < 12; k++) begin
      put(1'b1, 12'h001 << k);
      put(1'b0, ~(12'h001 << k));
    end
    put(1'b1, 12'hfff);
    put(1'b0, 12'h000);

    // R5 R6 R7 R8 R2 R3: six-button burst, patterns
    six_mode_i = 1'b1;
    cur_req = "R5";
    put(1'b0, 12'h000);
    for (int r = 0; r < 3; r++) begin
      logic [11:0] p;
      p = (r == 0) ? 12'h5a3 : (r == 1) ? 12'ha5c : 12'hf0f;
      cur_req = "R2"; put(1'b1, p);          // phase 1 high
      cur_req = "R3"; put(1'b0, p);          // phase 1 low
      cur_req = "R2"; put(1'b1, ~p);         // phase 2 high
      cur_req = "R6"; put(1'b0, ~p);         // phase 2 low
      cur_req = "R7"; put(1'b1, p);          // phase 3 high
      cur_req = "R8"; put(1'b0, p);          // phase 3 low
      cur_req = "R5"; put(1'b1, ~p);         // wrap to 0
      put(1'b0, ~p);
    end
    // R5: repeated high writes with no low do not advance
    cur_req = "R5";
    put(1'b1, 12'h111); put(1'b1, 12'h222); put(1'b0, 12'h333);
    put(1'b0, 12'h444); put(1'b1, 12'h555);

    // R10: idle timeout returns phase to 0
    cur_req = "R10";
    idle_lim_i = 16'd6;
    put(1'b0, 12'h0f0);
    put(1'b1, 12'h0f0); put(1'b0, 12'h0f0); put(1'b1, 12'h0f0);
    repeat (10) drive(1'b1, 1'b0, 12'h30c);
    put(1'b0, 12'h30c);
    put(1'b1, 12'h30c);

    // R11: rise meets timeout, phase 1
    cur_req = "R11";
    idle_lim_i = 16'd3;
    put(1'b0, 12'h9c3);
    repeat (8) drive(1'b0, 1'b0, 12'h9c3);
    drive(1'b1, 1'b0, 12'h9c3);
    drive(1'b1, 1'b0, 12'h9c3);
    drive(1'b0, 1'b1, 12'h9c3);
    drive(1'b1, 1'b1, 12'h9c3);
    drive(1'b0, 1'b1, 12'h9c3);
    // rise with write: no timeout
    idle_lim_i = 16'd1000;
    repeat (4) drive(1'b1, 1'b1, 12'h6a6);
    put(1'b0, 12'h6a6);

    // R1: reset mid-burst
    cur_req = "R1";
    put(1'b1, 12'h777);
    @(posedge clk); #5 rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #5 rst_ni = 1'b1;
    put(1'b0, 12'h777); put(1'b1, 12'h777);

    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule